// File: doc/BRIEF.md
# Hardware-Updated Field with Per-Bit Update Gating

This block holds one software-readable field that hardware keeps up to date. Hardware has three ways to change the field: a load that copies a data input, a clear strobe that drives bits to zero, and a set strobe that drives bits to one. A per-bit gating vector limits every hardware update to a chosen subset of bits. In enable mode a gate bit of 1 lets that bit change. In mask mode a gate bit of 1 freezes that bit. The field also drives AND, OR and XOR reductions of its current value, so that logic nearby can react to all-ones, any-one or parity conditions without decoding the field itself.

A build parameter chooses where the qualifiers come from. They are either dedicated input pins or bits of a software-writable control register inside the block. A second parameter chooses whether the load is active-high or active-low. A small CPU port gives read access to the field and the control register. It can also write the field when the field is built software-writable. The port accepts every request in the cycle it is presented and has no back-pressure. A read returns its data exactly one cycle after the request, with `rsp_valid` high for that single cycle.

Top module: `hwfld_top`

## Requirements
- R1: After reset the field holds RESET_VAL and `rsp_valid` is 0. The control register resets to: gate bits all ones in enable mode or all zeros in mask mode, clear bit 0, set bit 0, and load bit at its inactive level (1 when the load is active-low, else 0).
- R2: While the load qualifier is at its asserting level, the updatable bits of the field take `hw_data` at the next clock edge.
- R3: A set drives the updatable bits to 1 and a clear drives them to 0. When set and clear are active in the same cycle, set wins.
- R4: Updatable bits are the bits where the gate is 1 in enable mode (GATE_MODE=0), or the bits where the gate is 0 in mask mode (GATE_MODE=1). No hardware update ever changes the other bits.
- R5: Hardware updates take priority in the order set, then clear, then load. Any hardware update that is active beats a software field write made in the same cycle.
- R6: When no qualifier is active and no software write occurs, the field holds its value.
- R7: A write to address 0 replaces the field only when SW_WR=1. When SW_WR=0 the write is ignored.
- R8: With QUAL_SRC=1 the qualifiers come from the control register at address 1, and the dedicated qualifier pins are ignored. Layout: bits [W-1:0] gate, bit W clear, bit W+1 set, bit W+2 load. An update takes place in every cycle in which a control bit holds its asserting level.
- R9: `red_and`, `red_or` and `red_xor` are the AND, OR and XOR reductions of the current field value.
- R10: A read (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 in the next cycle. Its data is the field zero-extended for address 0, the control register for address 1, and 0 for any other address. Writes give no response.
- R11: With LOAD_LOW=1 the load qualifier asserts at level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 = field, 1 = control register |
| req_wdata | input | W+3 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | W+3 | Read data |
| hw_data | input | W | Hardware load value |
| hw_load | input | 1 | Dedicated load qualifier (polarity set by LOAD_LOW) |
| hw_clr | input | 1 | Dedicated clear strobe |
| hw_set | input | 1 | Dedicated set strobe |
| hw_gate | input | W | Dedicated enable or mask vector |
| fld_q | output | W | Current field value |
| red_and | output | 1 | AND reduction of the field |
| red_or | output | 1 | OR reduction of the field |
| red_xor | output | 1 | XOR reduction of the field |

## Verification
On every cycle, assertions check several properties of each hardware update. A set forces the updatable bits high, and a clear without a set forces them low. A load copies the data into the updatable bits. No update touches a frozen bit, and an idle cycle leaves the field alone. The same assertions check the one-cycle read response and the absence of a response to a write. Only the bench scenarios can show the rest. These are the exact values in the examples (enable 0xF0 giving 0xA1, mask 0xF0 giving 0x2B, 0x20 and 0x2F), the reset contents of the control register, a software write that is ignored or overridden, pins that are ignored when the register is the qualifier source, and the values of the reductions.

// File: rtl/hwfld_pkg.sv
package hwfld_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_FIELD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;

  typedef enum logic {GATE_ENABLE = 1'b0, GATE_MASK = 1'b1} gate_mode_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic ld;
  } hw_cmd_t;
endpackage

// File: rtl/hwfld_cpu_port.sv
module hwfld_cpu_port
  import hwfld_pkg::*;
#(
  parameter int W        = 8,
  parameter int GATE_MODE = 0,
  parameter bit LOAD_LOW = 1'b0,
  parameter bit SW_WR    = 1'b1,
  localparam int CW      = W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [CW-1:0]     rsp_rdata,
  input  logic [W-1:0]      fld_q,
  output logic [CW-1:0]     ctrl_q,
  output logic              fld_we,
  output logic [W-1:0]      fld_wdata
);
  localparam logic [W-1:0] GATE_RST = (GATE_MODE != 0) ? '0 : '1;
  localparam logic [CW-1:0] CTRL_RST = {LOAD_LOW, 1'b0, 1'b0, GATE_RST};

  logic rd_hit, wr_ctrl;
  logic [CW-1:0] rd_mux;

  assign rd_hit    = req_valid && !req_write;
  assign wr_ctrl   = req_valid && req_write && (req_addr == ADDR_CTRL);
  assign fld_we    = SW_WR && req_valid && req_write && (req_addr == ADDR_FIELD);
  assign fld_wdata = req_wdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= req_wdata;
  end

  always_comb begin
    unique case (req_addr)
      ADDR_FIELD: rd_mux = {{(CW-W){1'b0}}, fld_q};
      ADDR_CTRL:  rd_mux = ctrl_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_hit;
      if (rd_hit) rsp_rdata <= rd_mux;
    end
  end

  // R10: a read gets exactly one response in the next cycle
  p_rd_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R10: writes and idle cycles give no response
  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: rtl/hwfld_qual_sel.sv
module hwfld_qual_sel
  import hwfld_pkg::*;
#(
  parameter int W         = 8,
  parameter int GATE_MODE = 0,
  parameter bit LOAD_LOW  = 1'b0,
  parameter bit QUAL_SRC  = 1'b0,
  localparam int CW       = W + 3
) (
  input  logic [W-1:0]  hw_gate,
  input  logic          hw_load,
  input  logic          hw_clr,
  input  logic          hw_set,
  input  logic [CW-1:0] ctrl_q,
  output logic [W-1:0]  upd,
  output hw_cmd_t       cmd
);
  localparam int CLR_BIT = W;
  localparam int SET_BIT = W + 1;
  localparam int LD_BIT  = W + 2;

  logic [W-1:0] gate_src;
  logic         ld_raw;

  assign gate_src = QUAL_SRC ? ctrl_q[W-1:0]  : hw_gate;
  assign ld_raw   = QUAL_SRC ? ctrl_q[LD_BIT] : hw_load;
  assign cmd.clr  = QUAL_SRC ? ctrl_q[CLR_BIT] : hw_clr;
  assign cmd.set  = QUAL_SRC ? ctrl_q[SET_BIT] : hw_set;

  generate
    if (LOAD_LOW) begin : g_ld_low
      assign cmd.ld = !ld_raw;
    end else begin : g_ld_high
      assign cmd.ld = ld_raw;
    end
    if (GATE_MODE != 0) begin : g_mask
      assign upd = ~gate_src;
    end else begin : g_enable
      assign upd = gate_src;
    end
  endgenerate
endmodule

// File: rtl/hwfld_store.sv
module hwfld_store
  import hwfld_pkg::*;
#(
  parameter int          W         = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] upd,
  input  hw_cmd_t      cmd,
  input  logic [W-1:0] hw_data,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] fld_q,
  output logic         red_and,
  output logic         red_or,
  output logic         red_xor
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = fld_q;
    if (cmd.set)      nxt = fld_q | upd;
    else if (cmd.clr) nxt = fld_q & ~upd;
    else if (cmd.ld)  nxt = (fld_q & ~upd) | (hw_data & upd);
    else if (sw_we)   nxt = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= RESET_VAL;
    else        fld_q <= nxt;
  end

  assign red_and = &fld_q;
  assign red_or  = |fld_q;
  assign red_xor = ^fld_q;

  p_set_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.set |=> ((fld_q & $past(upd)) == $past(upd)));
  p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !cmd.set) |=> ((fld_q & $past(upd)) == '0));
  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.ld && !cmd.set && !cmd.clr) |=>
      ((fld_q & $past(upd)) == ($past(hw_data) & $past(upd))));
  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.set || cmd.clr || cmd.ld) |=>
      ((fld_q & ~$past(upd)) == ($past(fld_q) & ~$past(upd))));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.set || cmd.clr || cmd.ld || sw_we) |=> $stable(fld_q));
endmodule

// File: rtl/hwfld_top.sv
module hwfld_top
  import hwfld_pkg::*;
#(
  parameter int           W         = 8,
  parameter int           GATE_MODE = 0,
  parameter bit           LOAD_LOW  = 1'b0,
  parameter bit           QUAL_SRC  = 1'b0,
  parameter bit           SW_WR     = 1'b1,
  parameter logic [W-1:0] RESET_VAL = '0,
  localparam int          DW        = W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [W-1:0]      hw_data,
  input  logic              hw_load,
  input  logic              hw_clr,
  input  logic              hw_set,
  input  logic [W-1:0]      hw_gate,
  output logic [W-1:0]      fld_q,
  output logic              red_and,
  output logic              red_or,
  output logic              red_xor
);
  logic [DW-1:0] ctrl_q;
  logic          fld_we;
  logic [W-1:0]  fld_wdata;
  logic [W-1:0]  upd;
  hw_cmd_t       cmd;

  hwfld_cpu_port #(.W(W), .GATE_MODE(GATE_MODE), .LOAD_LOW(LOAD_LOW), .SW_WR(SW_WR)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fld_q(fld_q), .ctrl_q(ctrl_q),
    .fld_we(fld_we), .fld_wdata(fld_wdata)
  );

  hwfld_qual_sel #(.W(W), .GATE_MODE(GATE_MODE), .LOAD_LOW(LOAD_LOW), .QUAL_SRC(QUAL_SRC)) u_qual (
    .hw_gate(hw_gate), .hw_load(hw_load), .hw_clr(hw_clr), .hw_set(hw_set),
    .ctrl_q(ctrl_q), .upd(upd), .cmd(cmd)
  );

  hwfld_store #(.W(W), .RESET_VAL(RESET_VAL)) u_store (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cmd(cmd), .hw_data(hw_data),
    .sw_we(fld_we), .sw_data(fld_wdata), .fld_q(fld_q),
    .red_and(red_and), .red_or(red_or), .red_xor(red_xor)
  );
endmodule

// File: tb/hwfld_top_tb.sv
`timescale 1ns/1ps
module hwfld_top_tb;
  localparam int W = 8;
  localparam int DW = W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // DUT A: dedicated pins, enable mode, active-high load, software-writable
  logic a_rv = 0, a_rw = 0; logic [1:0] a_ra = 0; logic [DW-1:0] a_wd = 0;
  logic a_sv; logic [DW-1:0] a_sd;
  logic [W-1:0] a_hd = 0, a_hg = 0; logic a_ld = 0, a_cl = 0, a_st = 0;
  logic [W-1:0] a_q; logic a_and, a_or, a_xor;

  hwfld_top #(.W(W), .GATE_MODE(0), .LOAD_LOW(1'b0), .QUAL_SRC(1'b0),
              .SW_WR(1'b1), .RESET_VAL(8'h11)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_write(a_rw), .req_addr(a_ra),
    .req_wdata(a_wd), .rsp_valid(a_sv), .rsp_rdata(a_sd), .hw_data(a_hd),
    .hw_load(a_ld), .hw_clr(a_cl), .hw_set(a_st), .hw_gate(a_hg), .fld_q(a_q),
    .red_and(a_and), .red_or(a_or), .red_xor(a_xor));

  // DUT B: register-sourced qualifiers, mask mode, active-low load, read-only field
  logic b_rv = 0, b_rw = 0; logic [1:0] b_ra = 0; logic [DW-1:0] b_wd = 0;
  logic b_sv; logic [DW-1:0] b_sd;
  logic [W-1:0] b_hd = 0, b_hg = 0; logic b_ld = 1, b_cl = 0, b_st = 0;
  logic [W-1:0] b_q; logic b_and, b_or, b_xor;

  hwfld_top #(.W(W), .GATE_MODE(1), .LOAD_LOW(1'b1), .QUAL_SRC(1'b1),
              .SW_WR(1'b0), .RESET_VAL(8'h22)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_write(b_rw), .req_addr(b_ra),
    .req_wdata(b_wd), .rsp_valid(b_sv), .rsp_rdata(b_sd), .hw_data(b_hd),
    .hw_load(b_ld), .hw_clr(b_cl), .hw_set(b_st), .hw_gate(b_hg), .fld_q(b_q),
    .red_and(b_and), .red_or(b_or), .red_xor(b_xor));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic a_pulse(input logic [W-1:0] g, input logic [W-1:0] d,
                         input logic ld, input logic cl, input logic st);
    a_hg = g; a_hd = d; a_ld = ld; a_cl = cl; a_st = st;
    tick();
    a_ld = 0; a_cl = 0; a_st = 0;
  endtask

  task automatic a_write(input logic [1:0] addr, input logic [DW-1:0] d);
    a_rv = 1; a_rw = 1; a_ra = addr; a_wd = d;
    tick();
    a_rv = 0; a_rw = 0;
  endtask

  task automatic a_read(input logic [1:0] addr, output logic [DW-1:0] d, output logic v);
    a_rv = 1; a_rw = 0; a_ra = addr;
    tick();
    a_rv = 0;
    d = a_sd; v = a_sv;
  endtask

  task automatic b_write(input logic [1:0] addr, input logic [DW-1:0] d);
    b_rv = 1; b_rw = 1; b_ra = addr; b_wd = d;
    tick();
    b_rv = 0; b_rw = 0;
  endtask

  task automatic b_read(input logic [1:0] addr, output logic [DW-1:0] d, output logic v);
    b_rv = 1; b_rw = 0; b_ra = addr;
    tick();
    b_rv = 0;
    d = b_sd; v = b_sv;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic v;
    check("R1 field A", a_q, 8'h11);
    check("R1 field B", b_q, 8'h22);
    check("R1 rsp_valid", a_sv, 0);
    a_read(2'd1, d, v);
    check("R1 ctrl A enable reset", d, 11'h0FF);
    b_read(2'd1, d, v);
    check("R1 R11 ctrl B mask/low reset", d, 11'h400);
  endtask

  task automatic t_enable_updates();
    a_pulse(8'hF0, 8'hAB, 1, 0, 0);
    check("R2 R4 load enable F0", a_q, 8'hA1);
    a_pulse(8'hF0, 8'h00, 0, 1, 0);
    check("R3 R4 clear enable F0", a_q, 8'h01);
    a_pulse(8'hF0, 8'h00, 0, 0, 1);
    check("R3 R4 set enable F0", a_q, 8'hF1);
    a_pulse(8'h00, 8'h00, 1, 0, 0);
    check("R4 load with empty enable", a_q, 8'hF1);
    a_pulse(8'h0F, 8'h00, 0, 1, 1);
    check("R3 set wins over clear", a_q, 8'hFF);
    a_pulse(8'hFF, 8'h00, 0, 1, 0);
    check("R3 clear all", a_q, 8'h00);
  endtask

  task automatic t_priority();
    a_pulse(8'hFF, 8'h5A, 1, 0, 1);
    check("R5 set beats load", a_q, 8'hFF);
    a_pulse(8'h0F, 8'h5A, 1, 1, 0);
    check("R5 clear beats load", a_q, 8'hF0);
    a_hg = 8'hFF; a_cl = 1;
    a_rv = 1; a_rw = 1; a_ra = 2'd0; a_wd = 11'h077;
    tick();
    a_cl = 0; a_rv = 0; a_rw = 0;
    check("R5 hw clear beats sw write", a_q, 8'h00);
  endtask

  task automatic t_hold_and_sw();
    logic [DW-1:0] d; logic v;
    a_hd = 8'hEE; a_hg = 8'hFF;
    repeat (3) tick();
    check("R6 idle hold", a_q, 8'h00);
    a_write(2'd0, 11'h03C);
    check("R7 sw write applied", a_q, 8'h3C);
    check("R10 no response to write", a_sv, 0);
    a_read(2'd0, d, v);
    check("R10 read field valid", v, 1);
    check("R10 read field data", d, 11'h03C);
    a_read(2'd2, d, v);
    check("R10 unmapped reads zero", d, 0);
  endtask

  task automatic t_reductions();
    a_pulse(8'hFF, 8'h03, 1, 0, 0);
    check("R9 0x03 and/or/xor", {a_and, a_or, a_xor}, 3'b010);
    a_pulse(8'hFF, 8'hFF, 1, 0, 0);
    check("R9 0xFF and/or/xor", {a_and, a_or, a_xor}, 3'b110);
    a_pulse(8'hFF, 8'h00, 1, 0, 0);
    check("R9 0x00 and/or/xor", {a_and, a_or, a_xor}, 3'b000);
    a_pulse(8'hFF, 8'h01, 1, 0, 0);
    check("R9 0x01 and/or/xor", {a_and, a_or, a_xor}, 3'b011);
  endtask

  task automatic t_reg_source();
    logic [DW-1:0] d; logic v;
    b_hg = 8'hFF; b_hd = 8'hAB; b_ld = 0; b_cl = 1; b_st = 1;
    tick(); tick();
    b_ld = 1; b_cl = 0; b_st = 0;
    check("R8 dedicated pins ignored", b_q, 8'h22);
    b_write(2'd1, 11'h0F0);
    b_write(2'd1, 11'h4F0);
    check("R8 R11 R4 masked load", b_q, 8'h2B);
    b_write(2'd1, 11'h5F0);
    b_write(2'd1, 11'h4F0);
    check("R8 R3 masked clear", b_q, 8'h20);
    b_write(2'd1, 11'h6F0);
    b_write(2'd1, 11'h4F0);
    check("R8 R3 masked set", b_q, 8'h2F);
    b_write(2'd0, 11'h099);
    check("R7 sw write ignored when read-only", b_q, 8'h2F);
    b_read(2'd0, d, v);
    check("R7 R10 read back after ignored write", d, 11'h02F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_updates();
    t_priority();
    t_hold_and_sw();
    t_reductions();
    t_reg_source();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule